// File: doc/BRIEF.md
# Motor Driver Fault and Sleep Supervisor

This block watches the protection flags of a dual H-bridge motor driver and decides, every clock, which bridges may be driven, whether the internal regulator is on, whether the internal logic is held in reset, and whether the active-low fault output is pulled down. The analog comparators that detect overcurrent, overtemperature and undervoltage sit outside the block. It sees only their digital flags, plus the sleep input pin.

Overcurrent is handled separately for each bridge. A flag must stay high for a deglitch window before it counts. A confirmed event then turns off only the offending bridge for a fixed retry period. After that period the bridge is re-enabled on its own. Overtemperature stops both bridges until the flag drops. Undervoltage outranks everything else: it resets the logic, switches off the regulator, and cancels any retry in progress. Sleep entry and wake-up both go through fixed delays. All delays are parameters counted in clock cycles. The fault output reflects the current fault conditions only and is never latched.

Top module: `mdrv_fault_sup`

## Requirements
- R1: An overcurrent flag on a bridge counts only after it has been high for DEGLITCH_CYC consecutive clock edges while that bridge is driven. A pulse of DEGLITCH_CYC-1 edges leaves `bridge_en` and `fault_n` unchanged.
- R2: A confirmed overcurrent on bridge i clears `bridge_en[i]` and drives `fault_n` low right after the confirming edge. Every other bridge keeps its enable.
- R3: A tripped bridge stays off for exactly RETRY_CYC clock cycles and is then re-enabled. `fault_n` returns high if no other fault is active. If the flag is still high at that point, a fresh deglitch window starts.
- R4: One cycle after `ot_flag` is sampled high, all bits of `bridge_en` are 0 and `fault_n` is 0. One cycle after it is sampled low, these return to the values the other conditions give. A retry period that is running keeps counting through the overtemperature.
- R5: One cycle after `uv_flag` is sampled high, `logic_rst` is 1, `reg_en` is 0, `bridge_en` is all 0 and `fault_n` is 0. Undervoltage overrides sleep, wake and every other fault, and it cancels any pending overcurrent retry, so no trip remains once the supply recovers.
- R6: With the bridges running, `sleep_n` low is sampled for SLEEP_CYC edges with no effect. On the next edge `reg_en` and all bridge enables go to 0. If `sleep_n` returns high before then, the sleep request is cancelled and the bridges keep running.
- R7: On the first edge that samples `sleep_n` high while asleep, or `uv_flag` low after undervoltage or reset, `reg_en` goes to 1. The bridges are enabled only after WAKE_CYC further edges. If `sleep_n` falls during this wake delay, the block returns to sleep without enabling any bridge.
- R8: Overcurrent flags are ignored while a bridge is not being driven (asleep, waking, or during overtemperature). Holding a flag high through such a period causes no trip afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; behaves like undervoltage recovery when released |
| oc_flag | input | NUM_BRIDGES | Per-bridge overcurrent comparator flag, active high |
| ot_flag | input | 1 | Overtemperature comparator flag, active high |
| uv_flag | input | 1 | Supply undervoltage comparator flag, active high |
| sleep_n | input | 1 | Sleep pin, low requests sleep |
| bridge_en | output | NUM_BRIDGES | Per-bridge drive permission; 0 turns all FETs of that bridge off |
| reg_en | output | 1 | Internal regulator enable |
| logic_rst | output | 1 | Reset for the rest of the driver logic, high during undervoltage |
| fault_n | output | 1 | Active-low fault indication, unlatched |

## Verification
The bench drives the overcurrent flag for one edge less than the deglitch window, then for exactly the window. A design with an off-by-one counter either trips on the short pulse or needs one edge too many. The retry period is measured to the cycle, both with the flag released and with it held high. Holding the flag high must cause a second trip one deglitch window after re-enable, not an immediate one and not none. Overtemperature is applied in the middle of a retry: a design that latches the fault, or that restarts the retry, leaves the bridge off too long or frees it too early. Undervoltage during a trip must leave `fault_n` high after recovery, and a sleep request withdrawn early must never switch off the regulator.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  typedef enum logic [2:0] {
    PS_UVLO  = 3'd0,
    PS_WAKE  = 3'd1,
    PS_RUN   = 3'd2,
    PS_DOZE  = 3'd3,
    PS_SLEEP = 3'd4
  } pwr_state_e;

  // bits needed for a counter that runs from 0 to n-1
  function automatic int unsigned ctr_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // true on the last cycle of a window of `limit` cycles
  function automatic logic at_last(input logic [31:0] cnt, input int unsigned limit);
    return cnt == 32'(limit - 1);
  endfunction

endpackage

// File: rtl/mfs_oc_channel.sv
module mfs_oc_channel #(
  parameter int unsigned DEGLITCH_CYC = 700,
  parameter int unsigned RETRY_CYC    = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic arm,
  input  logic oc_raw,
  output logic tripped
);
  localparam int unsigned DW = mfs_pkg::ctr_bits(DEGLITCH_CYC);
  localparam int unsigned RW = mfs_pkg::ctr_bits(RETRY_CYC);

  logic [DW-1:0] dcnt;
  logic [RW-1:0] rcnt;

  logic oc_seen;
  logic oc_confirm;
  logic retry_done;

  assign oc_seen    = arm && oc_raw && !tripped;
  assign oc_confirm = oc_seen && mfs_pkg::at_last(32'(dcnt), DEGLITCH_CYC);
  assign retry_done = tripped && mfs_pkg::at_last(32'(rcnt), RETRY_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tripped <= 1'b0;
      dcnt    <= '0;
      rcnt    <= '0;
    end else if (clear) begin
      tripped <= 1'b0;
      dcnt    <= '0;
      rcnt    <= '0;
    end else if (tripped) begin
      dcnt <= '0;
      if (retry_done) begin
        tripped <= 1'b0;
        rcnt    <= '0;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end else if (oc_seen) begin
      if (oc_confirm) begin
        tripped <= 1'b1;
        dcnt    <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end else begin
      dcnt <= '0;
    end
  end

  AST_TRIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> $past(oc_raw) && $past(arm)); // R1

  AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    tripped && !retry_done && !clear |=> tripped); // R3

  AST_CLEAR_DROPS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !tripped); // R5

endmodule

// File: rtl/mfs_power_seq.sv
module mfs_power_seq #(
  parameter int unsigned SLEEP_CYC = 250000,
  parameter int unsigned WAKE_CYC  = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_flag,
  input  logic sleep_n,
  output logic drive_ok,
  output logic reg_en,
  output logic logic_rst
);
  import mfs_pkg::*;

  localparam int unsigned TMAX = (SLEEP_CYC > WAKE_CYC) ? SLEEP_CYC : WAKE_CYC;
  localparam int unsigned TW   = ctr_bits(TMAX);

  pwr_state_e st, st_nxt;
  logic [TW-1:0] tcnt;

  logic wake_done;
  logic sleep_done;

  assign wake_done  = (st == PS_WAKE) && sleep_n && at_last(32'(tcnt), WAKE_CYC);
  assign sleep_done = (st == PS_DOZE) && !sleep_n && at_last(32'(tcnt), SLEEP_CYC);

  always_comb begin
    st_nxt = st;
    if (uv_flag) begin
      st_nxt = PS_UVLO;
    end else begin
      unique case (st)
        PS_UVLO:  st_nxt = sleep_n ? PS_WAKE : PS_SLEEP;
        PS_WAKE:  if (!sleep_n) st_nxt = PS_SLEEP;
                  else if (wake_done) st_nxt = PS_RUN;
        PS_RUN:   if (!sleep_n) st_nxt = PS_DOZE;
        PS_DOZE:  if (sleep_n) st_nxt = PS_RUN;
                  else if (sleep_done) st_nxt = PS_SLEEP;
        PS_SLEEP: if (sleep_n) st_nxt = PS_WAKE;
        default:  st_nxt = PS_UVLO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= PS_UVLO;
      tcnt <= '0;
    end else begin
      st <= st_nxt;
      if (st_nxt != st) tcnt <= '0;
      else if (st == PS_WAKE || st == PS_DOZE) tcnt <= tcnt + 1'b1;
      else tcnt <= '0;
    end
  end

  assign drive_ok  = (st == PS_RUN) || (st == PS_DOZE);
  assign reg_en    = (st == PS_WAKE) || drive_ok;
  assign logic_rst = (st == PS_UVLO);

  AST_UV_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> logic_rst); // R5

  AST_SLEEP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_ok) && !logic_rst |-> $past(sleep_done)); // R6

  AST_WAKE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_ok) |-> $past(wake_done)); // R7

endmodule

// File: rtl/mdrv_fault_sup.sv
module mdrv_fault_sup #(
  parameter int unsigned NUM_BRIDGES  = 2,
  parameter int unsigned DEGLITCH_CYC = 700,
  parameter int unsigned RETRY_CYC    = 400000,
  parameter int unsigned SLEEP_CYC    = 250000,
  parameter int unsigned WAKE_CYC     = 250000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_BRIDGES-1:0] oc_flag,
  input  logic                   ot_flag,
  input  logic                   uv_flag,
  input  logic                   sleep_n,
  output logic [NUM_BRIDGES-1:0] bridge_en,
  output logic                   reg_en,
  output logic                   logic_rst,
  output logic                   fault_n
);
  logic                   drive_ok;
  logic                   ot_q;
  logic                   arm;
  logic [NUM_BRIDGES-1:0] oc_trip;

  mfs_power_seq #(
    .SLEEP_CYC (SLEEP_CYC),
    .WAKE_CYC  (WAKE_CYC)
  ) i_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .uv_flag   (uv_flag),
    .sleep_n   (sleep_n),
    .drive_ok  (drive_ok),
    .reg_en    (reg_en),
    .logic_rst (logic_rst)
  );

  // overtemperature is sampled once; undervoltage wipes it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ot_q <= 1'b0;
    else        ot_q <= ot_flag && !uv_flag;
  end

  assign arm = drive_ok && !ot_q;

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
    mfs_oc_channel #(
      .DEGLITCH_CYC (DEGLITCH_CYC),
      .RETRY_CYC    (RETRY_CYC)
    ) i_oc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (logic_rst),
      .arm     (arm),
      .oc_raw  (oc_flag[b]),
      .tripped (oc_trip[b])
    );

    assign bridge_en[b] = arm && !oc_trip[b];

    AST_TRIP_ISOLATES: assert property (@(posedge clk) disable iff (!rst_n)
      oc_trip[b] |-> !bridge_en[b] && !fault_n); // R2
  end

  assign fault_n = !(logic_rst || ot_q || (|oc_trip));

  AST_OT_STOPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |=> (bridge_en == '0) && !fault_n); // R4

  AST_UV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst |-> (bridge_en == '0) && !reg_en && !fault_n); // R5

endmodule

// File: tb/test_mdrv_fault_sup.sv
module test_mdrv_fault_sup;
  localparam int unsigned NB = 2;
  localparam int unsigned DG = 6;
  localparam int unsigned RT = 40;
  localparam int unsigned SL = 20;
  localparam int unsigned WK = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] oc_flag = '0;
  logic          ot_flag = 1'b0;
  logic          uv_flag = 1'b0;
  logic          sleep_n = 1'b1;
  logic [NB-1:0] bridge_en;
  logic          reg_en;
  logic          logic_rst;
  logic          fault_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  mdrv_fault_sup #(
    .NUM_BRIDGES (NB), .DEGLITCH_CYC (DG), .RETRY_CYC (RT),
    .SLEEP_CYC (SL), .WAKE_CYC (WK)
  ) i_mdrv_fault_sup (
    .clk (clk), .rst_n (rst_n), .oc_flag (oc_flag), .ot_flag (ot_flag),
    .uv_flag (uv_flag), .sleep_n (sleep_n), .bridge_en (bridge_en),
    .reg_en (reg_en), .logic_rst (logic_rst), .fault_n (fault_n)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, act=%0d cycles exp<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [NB-1:0] en, input logic reg_e,
                         input logic rst_o, input logic flt_n);
    chk(req, "bridge_en", 32'(bridge_en), 32'(en));
    chk(req, "reg_en",    32'(reg_en),    32'(reg_e));
    chk(req, "logic_rst", 32'(logic_rst), 32'(rst_o));
    chk(req, "fault_n",   32'(fault_n),   32'(flt_n));
  endtask

  task automatic t_reset_and_wake;
    @(negedge clk);
    chk_out("R5", 2'b00, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk_out("R7", 2'b00, 1'b1, 1'b0, 1'b1);
    step(WK - 1);
    chk("R7", "en before wake delay", 32'(bridge_en), 32'd0);
    step(1);
    chk_out("R7", 2'b11, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_r1_glitch;
    oc_flag[0] = 1'b1;
    step(DG - 1);
    oc_flag[0] = 1'b0;
    chk("R1", "en after short pulse", 32'(bridge_en), 32'd3);
    step(2);
    chk_out("R1", 2'b11, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_r2_r3_trip;
    oc_flag[0] = 1'b1;
    step(DG - 1);
    chk("R1", "en one edge short", 32'(bridge_en), 32'd3);
    step(1);
    oc_flag[0] = 1'b0;
    chk_out("R2", 2'b10, 1'b1, 1'b0, 1'b0);
    step(RT - 1);
    chk_out("R3", 2'b10, 1'b1, 1'b0, 1'b0);
    step(1);
    chk_out("R3", 2'b11, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_r3_persist;
    oc_flag[1] = 1'b1;
    step(DG);
    chk("R2", "bridge1 trip", 32'(bridge_en), 32'd1);
    step(RT);
    chk("R3", "retry re-enable", 32'(bridge_en), 32'd3);
    step(DG - 1);
    chk("R3", "fresh deglitch", 32'(bridge_en), 32'd3);
    step(1);
    chk("R3", "second trip", 32'(bridge_en), 32'd1);
    oc_flag[1] = 1'b0;
    step(RT);
    chk_out("R3", 2'b11, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_r4_thermal;
    ot_flag = 1'b1;
    step(1);
    chk_out("R4", 2'b00, 1'b1, 1'b0, 1'b0);
    ot_flag = 1'b0;
    step(1);
    chk_out("R4", 2'b11, 1'b1, 1'b0, 1'b1);
    oc_flag[0] = 1'b1;
    step(DG);
    oc_flag[0] = 1'b0;
    chk("R2", "trip before OT", 32'(bridge_en), 32'd2);
    ot_flag = 1'b1;
    step(1);
    chk("R4", "en in OT", 32'(bridge_en), 32'd0);
    ot_flag = 1'b0;
    step(1);
    chk_out("R4", 2'b10, 1'b1, 1'b0, 1'b0);
    step(RT - 3);
    chk("R4", "retry still running", 32'(bridge_en), 32'd2);
    step(1);
    chk_out("R4", 2'b11, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_r8_ot_mask;
    ot_flag = 1'b1;
    oc_flag = 2'b11;
    step(DG + 3);
    chk("R8", "fault in OT", 32'(fault_n), 32'd0);
    ot_flag = 1'b0;
    oc_flag = 2'b00;
    step(1);
    chk_out("R8", 2'b11, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_r6_sleep;
    sleep_n = 1'b0;
    step(SL);
    chk_out("R6", 2'b11, 1'b1, 1'b0, 1'b1);
    step(1);
    chk_out("R6", 2'b00, 1'b0, 1'b0, 1'b1);
    oc_flag = 2'b11;
    step(DG + 4);
    chk("R8", "fault while asleep", 32'(fault_n), 32'd1);
    oc_flag = 2'b00;
    sleep_n = 1'b1;
    step(1);
    chk_out("R7", 2'b00, 1'b1, 1'b0, 1'b1);
    sleep_n = 1'b0;
    step(1);
    chk_out("R7", 2'b00, 1'b0, 1'b0, 1'b1);
    sleep_n = 1'b1;
    step(1);
    step(WK - 1);
    chk("R7", "still waking", 32'(bridge_en), 32'd0);
    step(1);
    chk_out("R7", 2'b11, 1'b1, 1'b0, 1'b1);
    sleep_n = 1'b0;
    step(SL - 2);
    sleep_n = 1'b1;
    step(1);
    chk_out("R6", 2'b11, 1'b1, 1'b0, 1'b1);
    step(SL + 2);
    chk_out("R6", 2'b11, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_r5_uv;
    oc_flag[0] = 1'b1;
    step(DG);
    oc_flag[0] = 1'b0;
    chk("R2", "trip before UV", 32'(bridge_en), 32'd2);
    uv_flag = 1'b1;
    step(1);
    chk_out("R5", 2'b00, 1'b0, 1'b1, 1'b0);
    step(3);
    chk_out("R5", 2'b00, 1'b0, 1'b1, 1'b0);
    uv_flag = 1'b0;
    step(1);
    chk_out("R5", 2'b00, 1'b1, 1'b0, 1'b1);
    step(WK);
    chk_out("R5", 2'b11, 1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset_and_wake();
    t_r1_glitch();
    t_r2_r3_trip();
    t_r3_persist();
    t_r4_thermal();
    t_r8_ot_mask();
    t_r6_sleep();
    t_r5_uv();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule